// File: doc/BRIEF.md
# I2C Primitive Command Engine

This block is a byte-level I2C bus master that does not run whole transfers. It executes one bus primitive at a time. Software writes a command code together with a launch bit. The engine then performs a single step: a start or repeated start condition, a byte sent with the acknowledge sampled, a byte received with ACK or NACK returned, or a stop condition. When the step ends, the engine leaves a two-bit completion code and raises an interrupt flag. Software chains these primitives into transfers of any shape, one interrupt at a time.

Bus timing comes from a clock-time register. Each SCL period is cut into four quarter phases, and each quarter lasts sixteen ticks of an N-cycle prescaler. SCL and SDA are open-drain. Each is a pull-low enable output paired with a line-level input. A local reset bit in the control register stops any command in flight and holds the engine idle.

The sequencer has five states. IDLE waits for a launch. COND_ON plays a start or repeated start over one SCL period. COND_OFF plays a stop over one period. SHIFT moves nine bit slots of a byte. FINISH lasts one cycle, publishes the completion and returns to IDLE. Transitions: IDLE to COND_ON on opcode 1 or 2. IDLE to COND_OFF on opcode 10. IDLE to SHIFT on opcode 3, 6 or 7 while a bus session is open. IDLE to FINISH directly for an abort. COND_ON, COND_OFF and SHIFT go to FINISH after their last quarter phase. FINISH goes to IDLE.

Top module: `i2c_byte_engine`

## Requirements
- R1: Registers are at byte offsets 0x0 (control), 0x1 (clock time), 0x2 (command), 0x3 (data), 0x8 (flag clear) and 0xA (interrupt enable). A read of 0x2 returns {busy[7], status[6:5], 0[4], last launched opcode[3:0]}. After reset every readable field is 0 and both bus enables are off.
- R2: While control bit 0 is 1, the engine is idle within one cycle, both pull-low enables are off, a GO write launches nothing, and any open bus session is forgotten.
- R3: A command write with bit 7 set, made while idle, launches opcode [3:0]. Bit 7 of a command read is 1 while the command runs and 0 once it has finished.
- R4: A GO write made while a command runs changes neither the running command nor the opcode read back.
- R5: Opcodes 1 (start) and 2 (repeated start) make SDA fall while SCL is high, then leave SCL held low. They open a session and complete with status 0.
- R6: Opcode 3 shifts the data-register byte out MSB first with SDA changing only while SCL is low. It releases SDA in the ninth slot and completes with status 1 if SDA was low there, or 2 if it was high.
- R7: Opcodes 6 and 7 sample eight SDA bits MSB first into the byte read at 0x3. In the ninth slot, opcode 6 pulls SDA low and opcode 7 leaves it released. Both complete with status 0.
- R8: Opcode 10 makes SDA rise while SCL is high, releases both lines, closes the session and completes with status 0.
- R9: Opcodes 3, 6 and 7 with no open session, and any opcode not listed, complete with status 3 (abort) without touching the bus.
- R10: With clock-time value C, consecutive SCL rising edges within a byte are 64 x (C+1) clock cycles apart.
- R11: Every completion sets the interrupt flag. Writing 0x8 with bit 0 set clears it. If a clear and a completion fall in the same cycle, the flag ends up set. The irq output is the flag ANDed with bit 0 of 0xA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write byte offset |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 4 | Read byte offset |
| reg_rdata | output | 8 | Read data, combinational from reg_raddr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Two collisions can happen in the same cycle. The first is a GO write while the sequencer is busy. The bench issues a stop GO in the middle of a byte send and then checks that the opcode read back, the busy bit and the completed byte are all unchanged. The second is a flag-clear write landing in the very cycle a command completes. The bench writes the clear register on every cycle while the busy bit reads 1, so one of those writes is bound to meet the completion edge. It then requires irq to be high once busy has dropped.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [3:0] OPC_START     = 4'd1;
    localparam logic [3:0] OPC_RESTART   = 4'd2;
    localparam logic [3:0] OPC_SEND      = 4'd3;
    localparam logic [3:0] OPC_RECV_ACK  = 4'd6;
    localparam logic [3:0] OPC_RECV_NACK = 4'd7;
    localparam logic [3:0] OPC_STOP      = 4'd10;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTIME   = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_CMD     = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_FLAGCLR = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 4'hA;

    typedef enum logic [1:0] {
        CST_NORMAL = 2'd0,
        CST_ACK    = 2'd1,
        CST_NACK   = 2'd2,
        CST_ABORT  = 2'd3
    } cstat_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_COND_ON,
        SEQ_COND_OFF,
        SEQ_SHIFT,
        SEQ_FINISH
    } seq_t;

endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
    parameter int CT_W  = 8,
    parameter int STEPS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [CT_W-1:0] ctime,
    output logic            tick
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    logic [CT_W-1:0]   fine_q;
    logic [STEP_W-1:0] step_q;
    logic              fine_end;

    assign fine_end = (fine_q == ctime);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q <= '0;
            step_q <= '0;
        end else if (!en) begin
            fine_q <= '0;
            step_q <= '0;
        end else if (fine_end) begin
            fine_q <= '0;
            step_q <= (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
        end else begin
            fine_q <= fine_q + 1'b1;
        end
    end

    assign tick = en && fine_end && (step_q == STEP_LAST);

endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
    import i2c_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       launch,
    input  logic [3:0] op,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output cstat_t     status,
    output logic [7:0] rx_byte,
    output logic       scl_low,
    output logic       sda_low
);
    localparam logic [3:0] BIT_ACK = 4'd8;

    seq_t       st_q;
    logic [1:0] ph_q;
    logic [3:0] bit_q;
    logic [7:0] sh_q;
    logic       rd_q;
    logic       ackl_q;
    logic       sess_q;
    cstat_t     stat_q;
    logic [7:0] rx_q;
    logic       bit_low;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0;
            rd_q <= 1'b0; ackl_q <= 1'b0; sess_q <= 1'b0;
            stat_q <= CST_NORMAL; rx_q <= '0;
        end else if (clr) begin
            st_q <= SEQ_IDLE; ph_q <= '0; bit_q <= '0;
            sess_q <= 1'b0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: if (launch) begin
                    ph_q   <= '0;
                    bit_q  <= '0;
                    stat_q <= CST_NORMAL;
                    if (op == OPC_START || op == OPC_RESTART) begin
                        st_q <= SEQ_COND_ON;
                    end else if (op == OPC_STOP) begin
                        st_q <= SEQ_COND_OFF;
                    end else if (sess_q && op == OPC_SEND) begin
                        st_q <= SEQ_SHIFT; sh_q <= tx_byte; rd_q <= 1'b0;
                    end else if (sess_q && (op == OPC_RECV_ACK || op == OPC_RECV_NACK)) begin
                        st_q <= SEQ_SHIFT; rd_q <= 1'b1;
                        ackl_q <= (op == OPC_RECV_ACK);
                    end else begin
                        st_q <= SEQ_FINISH; stat_q <= CST_ABORT;
                    end
                end
                SEQ_COND_ON: if (tick) begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd3) begin st_q <= SEQ_FINISH; sess_q <= 1'b1; end
                end
                SEQ_COND_OFF: if (tick) begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd3) begin st_q <= SEQ_FINISH; sess_q <= 1'b0; end
                end
                SEQ_SHIFT: if (tick) begin
                    if (!(ph_q == 2'd1 && !scl_in)) ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd2) begin
                        if (bit_q == BIT_ACK) begin
                            if (!rd_q) stat_q <= sda_in ? CST_NACK : CST_ACK;
                        end else if (rd_q) begin
                            sh_q <= {sh_q[6:0], sda_in};
                        end
                    end
                    if (ph_q == 2'd3) begin
                        if (bit_q == BIT_ACK) begin
                            st_q <= SEQ_FINISH;
                            if (rd_q) rx_q <= sh_q;
                        end else begin
                            bit_q <= bit_q + 4'd1;
                            if (!rd_q) sh_q <= {sh_q[6:0], 1'b0};
                        end
                    end
                end
                SEQ_FINISH: st_q <= SEQ_IDLE;
                default:    st_q <= SEQ_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        bit_low = rd_q ? (bit_q == BIT_ACK && ackl_q) : (bit_q != BIT_ACK && !sh_q[7]);
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (st_q)
            SEQ_IDLE, SEQ_FINISH: scl_low = sess_q;
            SEQ_COND_ON: unique case (ph_q)
                2'd0:    scl_low = sess_q;
                2'd1:    ;
                2'd2:    sda_low = 1'b1;
                default: begin scl_low = 1'b1; sda_low = 1'b1; end
            endcase
            SEQ_COND_OFF: unique case (ph_q)
                2'd0:    begin scl_low = 1'b1; sda_low = 1'b1; end
                2'd1:    sda_low = 1'b1;
                default: ;
            endcase
            SEQ_SHIFT: begin
                scl_low = (ph_q == 2'd0) || (ph_q == 2'd3);
                sda_low = bit_low;
            end
            default: ;
        endcase
    end

    assign busy    = (st_q != SEQ_IDLE);
    assign done    = (st_q == SEQ_FINISH);
    assign status  = stat_q;
    assign rx_byte = rx_q;

    a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r6_sda_steady: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (st_q == SEQ_SHIFT && !scl_low && $past(st_q == SEQ_SHIFT) && $past(!scl_low))
        |-> $stable(sda_low));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int PHASE_STEPS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    input  logic              scl_in,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam int CT_W = REG_W;

    logic            ctl_rst_q;
    logic [CT_W-1:0] ctime_q;
    logic [3:0]      op_q;
    logic [7:0]      tx_q;
    logic            ien_q;
    logic            flag_q;

    logic   go_wr, launch, clr_wr, tick;
    logic   seq_busy, seq_done;
    cstat_t seq_stat;
    logic [7:0] seq_rx;

    assign go_wr  = reg_we && (reg_waddr == OFS_CMD) && reg_wdata[7];
    assign launch = go_wr && !seq_busy && !ctl_rst_q;
    assign clr_wr = reg_we && (reg_waddr == OFS_FLAGCLR) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_rst_q <= 1'b0; ctime_q <= '0; op_q <= '0;
            tx_q <= '0; ien_q <= 1'b0; flag_q <= 1'b0;
        end else begin
            if (reg_we && reg_waddr == OFS_CTRL)  ctl_rst_q <= reg_wdata[0];
            if (reg_we && reg_waddr == OFS_CTIME) ctime_q   <= reg_wdata;
            if (reg_we && reg_waddr == OFS_DATA)  tx_q      <= reg_wdata;
            if (reg_we && reg_waddr == OFS_IEN)   ien_q     <= reg_wdata[0];
            if (launch)                           op_q      <= reg_wdata[3:0];
            if (seq_done)    flag_q <= 1'b1;
            else if (clr_wr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_raddr)
            OFS_CTRL:    reg_rdata = {7'd0, ctl_rst_q};
            OFS_CTIME:   reg_rdata = ctime_q;
            OFS_CMD:     reg_rdata = {seq_busy, seq_stat, 1'b0, op_q};
            OFS_DATA:    reg_rdata = seq_rx;
            OFS_FLAGCLR: reg_rdata = {7'd0, flag_q};
            OFS_IEN:     reg_rdata = {7'd0, ien_q};
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = flag_q & ien_q;

    i2c_eng_tick #(.CT_W(CT_W), .STEPS(PHASE_STEPS)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(seq_busy), .ctime(ctime_q), .tick(tick)
    );

    i2c_eng_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(ctl_rst_q), .launch(launch),
        .op(reg_wdata[3:0]), .tx_byte(tx_q), .tick(tick),
        .scl_in(scl_in), .sda_in(sda_in), .busy(seq_busy), .done(seq_done),
        .status(seq_stat), .rx_byte(seq_rx), .scl_low(scl_oe), .sda_low(sda_oe)
    );

    a_r2_lreset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_q |=> (!seq_busy && !scl_oe && !sda_oe));

    a_r4_go_ignored: assert property (@(posedge clk) disable iff (!rst_n || ctl_rst_q)
        (seq_busy && !seq_done && go_wr) |=> (seq_busy && $stable(op_q)));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> flag_q);

    a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> seq_busy);

endmodule

// File: tb/i2c_byte_engine_bench.sv
module i2c_byte_engine_bench;

    typedef struct {
        int    st;
        bit    cd;
        int    d;
        bit    ct;
        int    tx;
        bit    cb;
        int    b8;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_waddr = '0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] reg_raddr = 4'h2;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_line, sda_line, slv_pull;

    int nchecks = 0, nfail = 0, mon_seen = 0;
    bit wd_hit = 0, ended = 0;
    exp_t sb[$];

    // bus slave model
    int       slv_mode = 0;
    logic [7:0] slv_rd = '0;
    int       slv_base = 0, fall_cnt = 0, slv_idx;
    logic [8:0] rise_sh = '0;
    time      last_rise = 0, period = 0;
    int       starts = 0, stops = 0;

    always #10 clk = ~clk;

    assign scl_line = !scl_oe;
    assign slv_idx  = fall_cnt - slv_base;
    assign slv_pull = (slv_mode == 1 && slv_idx == 8) ||
                      (slv_mode == 2 && slv_idx < 8 && !slv_rd[3'd7 - slv_idx[2:0]]);
    assign sda_line = !(sda_oe || slv_pull);

    always @(posedge scl_line) begin
        rise_sh   = {rise_sh[7:0], sda_line};
        period    = $time - last_rise;
        last_rise = $time;
    end
    always @(negedge scl_line) fall_cnt = fall_cnt + 1;
    always @(negedge sda_line) if (scl_line === 1'b1) starts = starts + 1;
    always @(posedge sda_line) if (scl_line === 1'b1) stops = stops + 1;

    i2c_byte_engine u_i2c_byte_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_waddr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic exp_t mk(int st, bit cd, int d, bit ct, int tx, bit cb, int b8, string req);
        exp_t e;
        e.st = st; e.cd = cd; e.d = d; e.ct = ct; e.tx = tx; e.cb = cb; e.b8 = b8; e.req = req;
        return e;
    endfunction

    // driver: pushes the expectation, launches, waits for the monitor
    task automatic do_cmd(input logic [3:0] op, input logic [7:0] tx, input int mode,
                          input logic [7:0] rd, input exp_t e, input bit probe);
        int tgt;
        if (op == 4'd3) wr(4'h3, tx);
        slv_mode = mode; slv_rd = rd; slv_base = fall_cnt;
        sb.push_back(e);
        tgt = mon_seen + 1;
        wr(4'h2, {4'b1000, op});
        if (probe) begin
            chk("R3 busy bit while running", int'(reg_rdata[7]), 1);
            chk("R3 opcode readback", int'(reg_rdata[3:0]), int'(op));
            wr(4'h2, 8'h8A);
            chk("R4 opcode after ignored GO", int'(reg_rdata[3:0]), int'(op));
            chk("R4 still busy after ignored GO", int'(reg_rdata[7]), 1);
        end
        while (mon_seen < tgt && !wd_hit) @(negedge clk);
        wr(4'h8, 8'h01);
    endtask

    // monitor: pops one expectation per completion
    initial begin
        forever begin
            @(posedge irq);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                @(negedge clk);
                chk({e.req, " busy cleared at completion"}, int'(reg_rdata[7]), 0);
                chk({e.req, " status"}, int'(reg_rdata[6:5]), e.st);
                if (e.cd) begin
                    reg_raddr = 4'h3;
                    #1;
                    chk({e.req, " data register"}, int'(reg_rdata), e.d);
                    reg_raddr = 4'h2;
                end
                if (e.ct) chk({e.req, " byte on bus"}, int'(rise_sh[8:1]), e.tx);
                if (e.cb) chk({e.req, " ninth bit"}, int'(rise_sh[0]), e.b8);
                mon_seen++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset command read", int'(reg_rdata), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset scl_oe", int'(scl_oe), 0);
        chk("R1 reset sda_oe", int'(sda_oe), 0);
        wr(4'hA, 8'h01);
        wr(4'h1, 8'h00);

        // R9: no session, and an unlisted opcode
        do_cmd(4'd3, 8'h11, 0, 8'h00, mk(3, 0, 0, 0, 0, 0, 0, "R9 send without start"), 0);
        chk("R9 bus untouched", int'(scl_oe) + int'(sda_oe), 0);
        do_cmd(4'd5, 8'h00, 0, 8'h00, mk(3, 0, 0, 0, 0, 0, 0, "R9 unknown opcode"), 0);

        // R5: start
        s0 = starts;
        do_cmd(4'd1, 8'h00, 0, 8'h00, mk(0, 0, 0, 0, 0, 0, 0, "R5 start"), 0);
        chk("R5 start condition seen", starts - s0, 1);
        chk("R5 SCL held low after start", int'(scl_oe), 1);

        // R6 sends, with R3/R4 probe and R10 at N=1
        do_cmd(4'd3, 8'hA5, 1, 8'h00, mk(1, 0, 0, 1, 8'hA5, 1, 0, "R6 send acked"), 1);
        chk("R10 SCL period N=1 (ns)", int'(period), 64 * 20);
        do_cmd(4'd3, 8'h3C, 0, 8'h00, mk(2, 0, 0, 1, 8'h3C, 1, 1, "R6 send nacked"), 0);

        // R5: repeated start
        s0 = starts;
        do_cmd(4'd2, 8'h00, 0, 8'h00, mk(0, 0, 0, 0, 0, 0, 0, "R5 repeated start"), 0);
        chk("R5 repeated start seen", starts - s0, 1);

        // R7: receives
        do_cmd(4'd6, 8'h00, 2, 8'h5A, mk(0, 1, 8'h5A, 1, 8'h5A, 1, 0, "R7 read with ACK"), 0);
        do_cmd(4'd7, 8'h00, 2, 8'hC3, mk(0, 1, 8'hC3, 1, 8'hC3, 1, 1, "R7 read with NACK"), 0);

        // R10: N=3
        wr(4'h1, 8'h02);
        do_cmd(4'd3, 8'h81, 1, 8'h00, mk(1, 0, 0, 1, 8'h81, 1, 0, "R10 send at N=3"), 0);
        chk("R10 SCL period N=3 (ns)", int'(period), 192 * 20);
        wr(4'h1, 8'h00);

        // R8: stop
        s0 = stops;
        do_cmd(4'd10, 8'h00, 0, 8'h00, mk(0, 0, 0, 0, 0, 0, 0, "R8 stop"), 0);
        chk("R8 stop condition seen", stops - s0, 1);
        chk("R8 lines released", int'(scl_oe) + int'(sda_oe), 0);

        // R11: clear written every cycle up to the completion
        begin
            int tgt;
            slv_mode = 0;
            sb.push_back(mk(0, 0, 0, 0, 0, 0, 0, "R11 start under clear storm"));
            tgt = mon_seen + 1;
            wr(4'h2, 8'h81);
            forever begin
                @(negedge clk);
                if (reg_rdata[7] !== 1'b1) begin reg_we = 1'b0; break; end
                reg_waddr = 4'h8; reg_wdata = 8'h01; reg_we = 1'b1;
            end
            chk("R11 set wins over same-cycle clear", int'(irq), 1);
            while (mon_seen < tgt && !wd_hit) @(negedge clk);
            wr(4'hA, 8'h00);
            chk("R11 irq masked by enable", int'(irq), 0);
            wr(4'hA, 8'h01);
            chk("R11 irq returns with enable", int'(irq), 1);
            wr(4'h8, 8'h01);
            chk("R11 irq after clear", int'(irq), 0);
        end

        // R2: local reset in the middle of a byte
        slv_mode = 1; slv_base = fall_cnt;
        wr(4'h3, 8'hF0);
        wr(4'h2, 8'h83);
        repeat (100) @(negedge clk);
        wr(4'h0, 8'h01);
        @(negedge clk);
        chk("R2 lines released under local reset", int'(scl_oe) + int'(sda_oe), 0);
        chk("R2 idle under local reset", int'(reg_rdata[7]), 0);
        wr(4'h2, 8'h81);
        chk("R2 GO ignored under local reset", int'(reg_rdata[7]), 0);
        chk("R2 no interrupt from discarded command", int'(irq), 0);
        wr(4'h0, 8'h00);
        slv_mode = 0;
        do_cmd(4'd3, 8'h22, 0, 8'h00, mk(3, 0, 0, 0, 0, 0, 0, "R2 R9 session dropped by local reset"), 0);

        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule